// File: doc/BRIEF.md
# Dual-Channel Serial Pattern Generator

This block drives two independent serial output channels. Each channel replays a stored seed of up to 64 bits on a data line while producing a matching output clock on a second line. Configuration is written through a simple word-addressed write port. For each channel it sets the seed, the number of valid seed bits, a divide ratio that fixes the output clock rate, the number of passes, an enable and the polarity of the output clock.

When a channel is enabled it takes a private copy of its configuration and runs three nested counters. The innermost counter divides the system clock into half periods of the output clock. The middle counter walks through the seed bits. The outer counter counts passes. After the last pass the channel emits a one-cycle done pulse, returns its lines to idle and sets a completion status bit. That status bit, gated by a per-channel enable, drives an interrupt output. To run again, the channel must be disabled and then enabled.

Top module: `dual_pattern_gen`

## Requirements
- R1: Register map (word addresses on `cfg_addr`):
  - 0 is control: bit c enables channel c, and bit 2+c sets the polarity of channel c.
  - 1 holds the interrupt enables in bits 1:0.
  - 2 holds the completion status in bits 1:0.
  - Channel c uses the base 4+4c: +0 is seed bits 31:0, +1 is seed bits 63:32, +2 is the divide field P in bits 15:0, and +3 holds the length field L in bits 5:0 and the pass field R in bits 25:16.
- R2: After reset, both output clocks and both data lines are 0, `done_o` is 0, `irq_o` is 0, and all registers are 0.
- R3: Seed bits are sent LSB first. Bit 0 of the low seed word goes first, and seed bits 32 to 63 come from the high word.
- R4: A length field L sends L+1 seed bits per pass (1 to 64).
- R5: A divide field P makes every half period of the output clock last P+1 system clocks. The first active edge comes P+1 clocks after the channel starts.
- R6: A pass field R plays the pattern R+1 times. `done_o` pulses for exactly one cycle, 2(P+1)(L+1)(R+1) clocks after the start edge, and the lines then return to idle.
- R7: While running, the data line changes only together with an output clock move to the inactive level, so it is stable on every active edge.
- R8: With polarity 0 the clock idles low and the active edge is rising. With polarity 1 it idles high and the active edge is falling. While disabled, the clock sits at its idle level and the data line is 0.
- R9: A done pulse sets the channel's status bit one clock later. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: `irq_o[c]` is high exactly when status bit c and interrupt enable bit c are both set.
- R11: Configuration writes made while a channel runs do not alter its pattern. They take effect after the channel is disabled and enabled again.
- R12: Clearing a channel's enable mid-run returns its lines to idle on the next clock with no done pulse. A later enable restarts from seed bit 0 and pass 0.
- R13: The two channels run independently and may be active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Word address of the write |
| cfg_wdata | input | 32 | Write data |
| ser_clk_o | output | NUM_CH (2) | Output clock per channel |
| ser_dat_o | output | NUM_CH (2) | Serial data per channel |
| done_o | output | NUM_CH (2) | One-cycle completion pulse per channel |
| irq_o | output | NUM_CH (2) | Completion interrupt per channel |

## Verification
The timing below counts from the clock edge k that accepts an enable write:
- The channel starts at edge k+1, showing seed bit 0 with the clock at its idle level.
- The output clock then moves every P+1 clocks.
- `done_o` is high after edge k+1+2(P+1)(L+1)(R+1).
- The status bit and interrupt follow one edge after that.
- A disable accepted at edge k forces idle lines after edge k+1.

The bench samples on the falling clock edge and counts cycles from the falling edge after the write. Under that counting, the done pulse must be seen at count 2(P+1)(L+1)(R+1)+2 and each clock move exactly P+1 counts after the previous one. Seed bits are captured at each move to the active level and compared with the expected order.

// File: rtl/pg_pkg.sv
package pg_pkg;
  parameter int PG_DATA_W = 32;
  parameter int PG_PDIV_W = 16;
  parameter int PG_REP_W  = 10;
  parameter int PG_REP_LSB = 16;
  localparam int PG_SEED_W = 2 * PG_DATA_W;
  localparam int PG_LEN_W  = $clog2(PG_SEED_W);

  typedef struct packed {
    logic [PG_SEED_W-1:0] seed;
    logic [PG_PDIV_W-1:0] pdiv;
    logic [PG_LEN_W-1:0]  len;
    logic [PG_REP_W-1:0]  reps;
  } pg_chcfg_t;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_DONE = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_regs.sv
module pg_regs
  import pg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PG_DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0]    done_i,
  output logic [NUM_CH-1:0]    en_o,
  output logic [NUM_CH-1:0]    pol_o,
  output pg_chcfg_t            cfg_o [NUM_CH],
  output logic [NUM_CH-1:0]    irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic [NUM_CH-1:0] en_q, pol_q, ie_q, st_q, clr;

  always_comb begin
    clr = '0;
    if (we_i && addr_i == A_STAT) clr = wdata_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
      ie_q  <= '0;
      st_q  <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) begin
        en_q  <= wdata_i[NUM_CH-1:0];
        pol_q <= wdata_i[2*NUM_CH-1:NUM_CH];
      end
      if (we_i && addr_i == A_IEN) ie_q <= wdata_i[NUM_CH-1:0];
      st_q <= (st_q & ~clr) | done_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    localparam logic [ADDR_W-3:0] BASE = (ADDR_W-2)'(c + 1);
    pg_chcfg_t q;
    logic hit;
    assign hit = we_i && (addr_i[ADDR_W-1:2] == BASE);

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        case (addr_i[1:0])
          2'd0: q.seed[PG_DATA_W-1:0]         <= wdata_i;
          2'd1: q.seed[PG_SEED_W-1:PG_DATA_W] <= wdata_i;
          2'd2: q.pdiv                        <= wdata_i[PG_PDIV_W-1:0];
          default: begin
            q.len  <= wdata_i[PG_LEN_W-1:0];
            q.reps <= wdata_i[PG_REP_LSB +: PG_REP_W];
          end
        endcase
      end
    end
    assign cfg_o[c] = q;
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign irq_o = st_q & ie_q;
endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic      pol_i,
  input  pg_chcfg_t cfg_i,
  output logic      ser_clk_o,
  output logic      ser_dat_o,
  output logic      done_o
);
  pg_state_e            st;
  pg_chcfg_t            sh;
  logic                 pol_sh;
  logic [PG_PDIV_W-1:0] pcnt;
  logic [PG_LEN_W-1:0]  bidx;
  logic [PG_REP_W-1:0]  rcnt;
  logic                 clk_q, dat_q, done_q;
  logic                 at_active;

  // Output clock currently sits at its active level.
  assign at_active = (clk_q != pol_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PG_IDLE;
      sh     <= '0;
      pol_sh <= 1'b0;
      pcnt   <= '0;
      bidx   <= '0;
      rcnt   <= '0;
      clk_q  <= 1'b0;
      dat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        PG_IDLE: begin
          clk_q <= pol_i;
          dat_q <= 1'b0;
          if (en_i) begin
            st     <= PG_RUN;
            sh     <= cfg_i;
            pol_sh <= pol_i;
            pcnt   <= '0;
            bidx   <= '0;
            rcnt   <= '0;
            dat_q  <= cfg_i.seed[0];
          end
        end
        PG_RUN: begin
          if (!en_i) begin
            st    <= PG_IDLE;
            clk_q <= pol_i;
            dat_q <= 1'b0;
          end else if (pcnt == sh.pdiv) begin
            pcnt  <= '0;
            clk_q <= ~clk_q;
            if (at_active) begin
              if (bidx == sh.len) begin
                bidx <= '0;
                if (rcnt == sh.reps) begin
                  st     <= PG_DONE;
                  done_q <= 1'b1;
                  dat_q  <= 1'b0;
                end else begin
                  rcnt  <= rcnt + 1'b1;
                  dat_q <= sh.seed[0];
                end
              end else begin
                bidx  <= bidx + 1'b1;
                dat_q <= sh.seed[bidx + 1'b1];
              end
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        PG_DONE: begin
          clk_q <= pol_i;
          dat_q <= 1'b0;
          if (!en_i) st <= PG_IDLE;
        end
        default: st <= PG_IDLE;
      endcase
    end
  end

  assign ser_clk_o = clk_q;
  assign ser_dat_o = dat_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dual_pattern_gen.sv
module dual_pattern_gen
  import pg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = $clog2(4 * (NUM_CH + 1))
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [PG_DATA_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0]    ser_clk_o,
  output logic [NUM_CH-1:0]    ser_dat_o,
  output logic [NUM_CH-1:0]    done_o,
  output logic [NUM_CH-1:0]    irq_o
);
  logic [NUM_CH-1:0] en_w, pol_w, done_w;
  pg_chcfg_t         cfg_w [NUM_CH];

  pg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .done_i  (done_w),
    .en_o    (en_w),
    .pol_o   (pol_w),
    .cfg_o   (cfg_w),
    .irq_o   (irq_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pg_channel u_ch (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_w[c]),
      .pol_i     (pol_w[c]),
      .cfg_i     (cfg_w[c]),
      .ser_clk_o (ser_clk_o[c]),
      .ser_dat_o (ser_dat_o[c]),
      .done_o    (done_w[c])
    );
  end

  assign done_o = done_w;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] pol,
  input logic [NUM_CH-1:0] ser_clk,
  input logic [NUM_CH-1:0] ser_dat,
  input logic [NUM_CH-1:0] done
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8 / R12: a channel seen disabled idles its lines on the next clock
    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (rst)
      !$past(en[c]) |-> (ser_clk[c] == $past(pol[c])) && !ser_dat[c]);

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done[c] |=> !done[c]);

    // R6 / R12: completion only arises from a channel that was enabled
    a_r6_done_while_enabled: assert property (@(posedge clk) disable iff (rst)
      done[c] |-> $past(en[c]));

    // R7: during a run the data line moves only together with the clock
    a_r7_dat_with_clk: assert property (@(posedge clk) disable iff (rst)
      (en[c] && $past(en[c]) && $past(en[c], 2) && !$stable(ser_dat[c]))
        |-> !$stable(ser_clk[c]));
  end
endmodule

bind dual_pattern_gen pg_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en_w),
  .pol     (pol_w),
  .ser_clk (ser_clk_o),
  .ser_dat (ser_dat_o),
  .done    (done_o)
);

// File: tb/dual_pattern_gen_bench.sv
module dual_pattern_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  ser_clk_o, ser_dat_o, done_o, irq_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dual_pattern_gen u_dual_pattern_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
    .done_o(done_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg(input int ch, input logic [63:0] seed, input int p,
                     input int l, input int r);
    wr(4 + 4*ch, seed[31:0]);
    wr(5 + 4*ch, seed[63:32]);
    wr(6 + 4*ch, 32'(p));
    wr(7 + 4*ch, (32'(r) << 16) | 32'(l));
  endtask

  // Called right after the enable write; counts from the falling edge after it.
  task automatic capture(input int ch, input logic pol, input logic [63:0] seed,
                         input int p, input int l, input int r, input string tag,
                         input bit mid, input logic [31:0] midv);
    int n = 1, nbits = 0, last_chg = 2, badbit = 0, badgap = 0, done_n = -1;
    int exp_bits = (l + 1) * (r + 1);
    int t = 2 * (p + 1) * exp_bits;
    logic prev = ser_clk_o[ch];
    while (done_n < 0 && n < t + 50) begin
      @(negedge clk);
      n++;
      if (mid && n == 6) begin
        cfg_we = 1'b1; cfg_addr = 4'(4 + 4*ch); cfg_wdata = midv;
      end else if (mid && n == 7) begin
        cfg_we = 1'b0;
      end
      if (ser_clk_o[ch] !== prev) begin
        if (n - last_chg != p + 1) badgap++;
        last_chg = n;
        if (prev == pol) begin
          if (ser_dat_o[ch] !== seed[nbits % (l + 1)]) badbit++;
          nbits++;
        end
      end
      prev = ser_clk_o[ch];
      if (done_o[ch]) done_n = n;
    end
    chk(done_n == t + 2, "R6", {tag, " done cycle"}, done_n, t + 2);
    chk(nbits == exp_bits, "R4/R6", {tag, " bits sent"}, nbits, exp_bits);
    chk(badbit == 0, "R3/R7", {tag, " bit mismatches"}, badbit, 0);
    chk(badgap == 0, "R5", {tag, " half-period errors"}, badgap, 0);
    @(negedge clk);
    chk(done_o[ch] == 1'b0, "R6", {tag, " done width"}, done_o[ch], 0);
    chk(ser_clk_o[ch] == pol && ser_dat_o[ch] == 1'b0, "R6/R8",
        {tag, " idle after done"}, {ser_clk_o[ch], ser_dat_o[ch]}, {pol, 1'b0});
  endtask

  task automatic t_reset;
    chk(ser_clk_o == 2'b00, "R2", "reset clk", ser_clk_o, 0);
    chk(ser_dat_o == 2'b00, "R2", "reset dat", ser_dat_o, 0);
    chk(done_o == 2'b00 && irq_o == 2'b00, "R2", "reset done/irq",
        {done_o, irq_o}, 0);
  endtask

  task automatic t_basic;
    cfg(0, 64'h0000_0000_0000_00A5, 0, 7, 0);
    wr(0, 32'h1);
    capture(0, 1'b0, 64'h0000_0000_0000_00A5, 0, 7, 0, "R1 basic", 1'b0, '0);
    chk(irq_o[0] == 1'b0, "R10", "irq masked", irq_o[0], 0);
    wr(1, 32'h1);
    chk(irq_o[0] == 1'b1, "R9/R10", "irq after enable", irq_o[0], 1);
    wr(2, 32'h2);
    chk(irq_o[0] == 1'b1, "R9", "write 0 keeps status", irq_o[0], 1);
    wr(2, 32'h1);
    chk(irq_o[0] == 1'b0, "R9", "W1C clears", irq_o[0], 0);
    wr(0, 32'h0);
  endtask

  task automatic t_long;
    logic [63:0] s = 64'hF0E1_D2C3_00FF_1234;
    cfg(0, s, 1, 63, 1);
    wr(0, 32'h1);
    capture(0, 1'b0, s, 1, 63, 1, "R3 64-bit", 1'b0, '0);
    chk(irq_o[0] == 1'b1, "R9", "status after long run", irq_o[0], 1);
    wr(2, 32'h3);
    wr(0, 32'h0);
  endtask

  task automatic t_pol;
    logic [63:0] s = 64'h0000_0000_0000_0016;
    cfg(1, s, 2, 4, 2);
    wr(0, 32'h8);
    @(negedge clk);
    chk(ser_clk_o[1] == 1'b1 && ser_dat_o[1] == 1'b0, "R8", "pol1 idle high",
        {ser_clk_o[1], ser_dat_o[1]}, 2);
    wr(0, 32'hA);
    capture(1, 1'b1, s, 2, 4, 2, "R8 pol1", 1'b0, '0);
    wr(2, 32'h3);
    wr(0, 32'h0);
    @(negedge clk);
    chk(ser_clk_o[1] == 1'b0, "R8", "pol0 idle low", ser_clk_o[1], 0);
  endtask

  task automatic t_midwrite;
    logic [63:0] a = 64'h0000_0000_0000_C35A;
    logic [63:0] b = 64'h0000_0000_0000_0F69;
    cfg(0, a, 1, 15, 0);
    wr(0, 32'h1);
    capture(0, 1'b0, a, 1, 15, 0, "R11 old pattern", 1'b1, b[31:0]);
    wr(0, 32'h0);
    wr(0, 32'h1);
    capture(0, 1'b0, b, 1, 15, 0, "R11 new pattern", 1'b0, '0);
    wr(2, 32'h3);
    wr(0, 32'h0);
  endtask

  task automatic t_abort;
    logic [63:0] s = 64'h0000_0000_9E37_79B9;
    bit saw = 0;
    cfg(0, s, 3, 31, 3);
    wr(1, 32'h3);
    wr(0, 32'h1);
    repeat (20) @(negedge clk);
    wr(0, 32'h0);
    @(negedge clk);
    chk(ser_clk_o[0] == 1'b0 && ser_dat_o[0] == 1'b0, "R12", "idle after abort",
        {ser_clk_o[0], ser_dat_o[0]}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done_o[0] || irq_o[0]) saw = 1;
    end
    chk(!saw, "R12", "no done after abort", saw, 0);
    wr(0, 32'h1);
    capture(0, 1'b0, s, 3, 31, 3, "R12 restart", 1'b0, '0);
    wr(2, 32'h3);
    wr(0, 32'h0);
  endtask

  task automatic t_both;
    logic [63:0] s0 = 64'h0000_0000_0000_6D2B;
    logic [63:0] s1 = 64'h0000_0000_0000_0025;
    bit seen1 = 0;
    cfg(0, s0, 0, 15, 0);
    cfg(1, s1, 4, 5, 1);
    wr(0, 32'h3);
    capture(0, 1'b0, s0, 0, 15, 0, "R13 ch0 with ch1 active", 1'b0, '0);
    chk(ser_clk_o[1] == 1'b1 || done_o[1] == 1'b0, "R13", "ch1 still running",
        done_o[1], 0);
    for (int i = 0; i < 200 && !seen1; i++) begin
      @(negedge clk);
      if (done_o[1]) seen1 = 1;
    end
    chk(seen1, "R13", "ch1 completes", seen1, 1);
    @(negedge clk);
    chk(irq_o == 2'b11, "R13/R10", "both statuses", irq_o, 3);
    wr(2, 32'h3);
    wr(0, 32'h0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_long();
    t_pol();
    t_midwrite();
    t_abort();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule